// File: doc/BRIEF.md
# Operand and Status Register Block

This block is a small set of memory-mapped registers on a plain synchronous bus. The bus carries an address, a write strobe with write data, and a read strobe with registered read data. Two operand registers feed an adder. A hardware-owned flag register records properties of the sum. A control register drives a bank of indicator outputs. A write-only register drives an external converter port.

The registers do not all behave like memory. The flag register can only be read. The converter register can only be written. Reading the control register does not return the written value. It returns a status input that comes from the outside and reports what the indicators are really doing.

Top module: `opflag_regs`

## Requirements
- R1: After a synchronous active-high reset, every register, `rdData`, `ledOut` and `dacOut` are all zero.
- R2: Address 0 (operand A) and address 1 (operand B) can be read and written. A read returns the last value written to that address.
- R3: Bit 0 of the flag register (address 2) is 1 exactly when the low DATA_W bits of A+B are zero. The flag register is recomputed on every clock from the operand register contents, so it reflects a new operand value one clock after the write.
- R4: Bit 1 of the flag register is the most significant bit of the DATA_W-bit sum, meaning the sum is negative.
- R5: Bit 2 of the flag register is the carry out of A+B. Flag bits 3 and up read as zero.
- R6: A bus write to the flag register address has no effect on its contents.
- R7: A write to the control register (address 3) appears on `ledOut` after the write edge.
- R8: A read of address 3 returns the value of `statIn` sampled at the read edge, whatever was written there.
- R9: A write to the converter register (address 4) appears on `dacOut` after the write edge. A read of address 4 returns zero.
- R10: `rdData` changes only at an edge where `rdEn` is high. It then shows the addressed value on the following cycle. A read at the same edge as a write returns the value from before the write. Addresses 5 and above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Registered read data |
| ledOut | output | DATA_W | Indicator drive from the control register |
| statIn | input | DATA_W | Observed indicator status |
| dacOut | output | DATA_W | Converter data |

## Verification
The bench builds the block with the defaults, DATA_W = 8 and ADDR_W = 3. With those values, carry, sign and zero boundaries such as 0x80+0x80 and 0xFF+0x01 are easy to hit directly. The 3-bit address also makes three unmapped addresses (5 to 7) reachable by the random traffic. That traffic mixes writes and reads over all eight addresses. It drives a `statIn` value that differs from the written control value, so reading back the written value would be caught.

// File: rtl/opflag_pkg.sv
package opflag_pkg;
  // Address map; software depends on these offsets
  localparam int ADR_OPA  = 0;
  localparam int ADR_OPB  = 1;
  localparam int ADR_FLAG = 2;
  localparam int ADR_CTL  = 3;
  localparam int ADR_DAC  = 4;

  // Flag bit positions
  localparam int FLG_ZERO  = 0;
  localparam int FLG_NEG   = 1;
  localparam int FLG_CARRY = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OPA,
    SEL_OPB,
    SEL_FLAG,
    SEL_STAT
  } rdSel_e;

  typedef struct packed {
    logic   wrOpA;
    logic   wrOpB;
    logic   wrCtl;
    logic   wrDac;
    logic   rdStb;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/opflag_ctrl.sv
module opflag_ctrl
  import opflag_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobes_t          stb
);
  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    stb.rdStb = rdEn;
    case (int'(addr))
      ADR_OPA:  begin stb.wrOpA = wrEn; stb.rdSel = SEL_OPA;  end
      ADR_OPB:  begin stb.wrOpB = wrEn; stb.rdSel = SEL_OPB;  end
      ADR_FLAG: begin                   stb.rdSel = SEL_FLAG; end
      ADR_CTL:  begin stb.wrCtl = wrEn; stb.rdSel = SEL_STAT; end
      ADR_DAC:  begin stb.wrDac = wrEn;                       end
      default:  begin                                         end
    endcase
  end

  // At most one register is written per cycle
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.wrOpA, stb.wrOpB, stb.wrCtl, stb.wrDac}));

  // The flag address never produces a write strobe
  assert_flag_ro_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && int'(addr) == ADR_FLAG) |-> !(stb.wrOpA || stb.wrOpB || stb.wrCtl || stb.wrDac));
endmodule

// File: rtl/opflag_dpath.sv
module opflag_dpath
  import opflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ledOut,
  output logic [DATA_W-1:0] dacOut
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] opA, opB, flagReg, ctlReg, dacReg;
  logic [SUM_W-1:0]  sumWide;
  logic [DATA_W-1:0] flagNext;
  logic [DATA_W-1:0] rdNext;

  assign sumWide = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    flagNext            = '0;
    flagNext[FLG_ZERO]  = (sumWide[DATA_W-1:0] == '0);
    flagNext[FLG_NEG]   = sumWide[DATA_W-1];
    flagNext[FLG_CARRY] = sumWide[DATA_W];
  end

  always_comb begin
    case (stb.rdSel)
      SEL_OPA:  rdNext = opA;
      SEL_OPB:  rdNext = opB;
      SEL_FLAG: rdNext = flagReg;
      SEL_STAT: rdNext = statIn;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opA     <= '0;
      opB     <= '0;
      flagReg <= '0;
      ctlReg  <= '0;
      dacReg  <= '0;
      rdData  <= '0;
    end else begin
      if (stb.wrOpA) opA    <= wrData;
      if (stb.wrOpB) opB    <= wrData;
      if (stb.wrCtl) ctlReg <= wrData;
      if (stb.wrDac) dacReg <= wrData;
      flagReg <= flagNext;
      if (stb.rdStb) rdData <= rdNext;
    end
  end

  assign ledOut = ctlReg;
  assign dacOut = dacReg;

  assert_opa_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stb.wrOpA |=> $stable(opA));
  assert_opb_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stb.wrOpB |=> $stable(opB));
  assert_led_follow_R7: assert property (@(posedge clk) disable iff (rst)
    stb.wrCtl |=> ledOut == $past(wrData));
  assert_dac_follow_R9: assert property (@(posedge clk) disable iff (rst)
    stb.wrDac |=> dacOut == $past(wrData));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !stb.rdStb |=> $stable(rdData));
  assert_stat_read_R8: assert property (@(posedge clk) disable iff (rst)
    (stb.rdStb && stb.rdSel == SEL_STAT) |=> rdData == $past(statIn));
endmodule

// File: rtl/opflag_regs.sv
module opflag_regs
  import opflag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ledOut,
  input  logic [DATA_W-1:0] statIn,
  output logic [DATA_W-1:0] dacOut
);
  strobes_t stb;

  opflag_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  opflag_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .statIn(statIn),
    .rdData(rdData), .ledOut(ledOut), .dacOut(dacOut)
  );

  // Converter register reads back as zero
  assert_dac_rdzero_R9: assert property (@(posedge clk) disable iff (rst)
    (rdEn && int'(addr) == ADR_DAC) |=> rdData == '0);
endmodule

// File: tb/opflag_regs_tb.sv
module opflag_regs_tb_top;
  localparam int DW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic [DW-1:0] rdData, ledOut, dacOut;
  logic [DW-1:0] statIn = '0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  logic [DW-1:0] mA = '0, mB = '0, mCtl = '0, mDac = '0;

  opflag_regs #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .ledOut(ledOut), .statIn(statIn), .dacOut(dacOut)
  );

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] expFlags(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW:0] s;
    logic [DW-1:0] f;
    s = {1'b0, a} + {1'b0, b};
    f = '0;
    f[0] = (s[DW-1:0] == '0);
    f[1] = s[DW-1];
    f[2] = s[DW];
    return f;
  endfunction

  function automatic logic [DW-1:0] expRead(int a);
    case (a)
      0: return mA;
      1: return mB;
      2: return expFlags(mA, mB);
      3: return statIn;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic busWrite(int a, logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      0: mA = d;
      1: mB = d;
      3: mCtl = d;
      4: mDac = d;
      default: ;
    endcase
  endtask

  task automatic busRead(int a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic flagCase(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] exp, string req);
    logic [DW-1:0] d;
    busWrite(0, a);
    busWrite(1, b);
    idle();
    busRead(2, d);
    chk(req, d, exp);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] held;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdData", rdData, '0);
    chk("R1 ledOut", ledOut, '0);
    chk("R1 dacOut", dacOut, '0);
    busRead(2, d); chk("R1 flags zero-sum after reset", d, 8'h01);
    busRead(0, d); chk("R1 opA", d, '0);

    // R2 operand readback
    busWrite(0, 8'h3C); busRead(0, d); chk("R2 opA", d, 8'h3C);
    busWrite(1, 8'hA5); busRead(1, d); chk("R2 opB", d, 8'hA5);

    // R3/R4/R5 flag corners
    flagCase(8'h80, 8'h80, 8'h05, "R3 R5 zero+carry 80+80");
    flagCase(8'hFF, 8'h01, 8'h05, "R3 R5 FF+01");
    flagCase(8'h7F, 8'h01, 8'h02, "R4 neg 7F+01");
    flagCase(8'h00, 8'h00, 8'h01, "R3 zero 00+00");
    flagCase(8'hF0, 8'h20, 8'h04, "R5 carry only F0+20");
    flagCase(8'hFF, 8'hFF, 8'h06, "R4 R5 FF+FF");
    flagCase(8'h12, 8'h34, 8'h00, "R3 no flags 12+34");

    // R6 write to flags ignored
    busWrite(2, 8'hFF); idle();
    busRead(2, d); chk("R6 flag write ignored", d, 8'h00);
    busRead(0, d); chk("R6 opA untouched", d, 8'h12);

    // R7/R8 control vs status
    statIn = 8'h0F;
    busWrite(3, 8'hC3);
    chk("R7 ledOut", ledOut, 8'hC3);
    busRead(3, d); chk("R8 status read", d, 8'h0F);

    // R9 converter
    busWrite(4, 8'h99);
    chk("R9 dacOut", dacOut, 8'h99);
    busRead(4, d); chk("R9 dac reads zero", d, 8'h00);

    // R10 hold without rdEn, unmapped, read during write
    busRead(0, d); held = d;
    @(negedge clk); addr = 3'd1;
    @(negedge clk); addr = 3'd2;
    @(negedge clk);
    chk("R10 rdData holds", rdData, held);
    busWrite(6, 8'h77);
    busRead(6, d); chk("R10 unmapped reads zero", d, '0);
    busRead(0, d); chk("R10 unmapped write no effect", d, 8'h12);
    @(negedge clk);
    addr = 3'd0; wrData = 8'h55; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; mA = 8'h55;
    chk("R10 read-during-write old value", rdData, 8'h12);

    // Random traffic
    for (int i = 0; i < 150; i++) begin
      int wa, ra;
      logic [DW-1:0] v;
      wa = int'($urandom_range(0, 7));
      v  = DW'($urandom);
      statIn = DW'($urandom);
      if ($urandom_range(0, 3) != 0) busWrite(wa, v);
      idle();
      ra = int'($urandom_range(0, 7));
      busRead(ra, d);
      chk($sformatf("R2 R3 R8 R9 R10 random read addr %0d", ra), d, expRead(ra));
      chk("R7 random ledOut", ledOut, mCtl);
      chk("R9 random dacOut", dacOut, mDac);
    end

    finishRun();
  end
endmodule